// File: doc/BRIEF.md
# ESF Data-Link Bit Buffer

This block moves the 4 kbit/s data-link channel of a T1 Extended Superframe between the line and a processor through holding registers. On receive, it picks the data-link bit out of the framing-bit position of the odd-numbered frames and gathers the bits in a shadow register. When a set is complete it copies the whole set into the read registers in a single cycle and raises a sticky interrupt. On transmit, it copies the processor-written registers into a shadow register at the multiframe end. It raises a sticky interrupt asking for the next data, and presents one shadow bit per odd frame to the framer.

Frame timing comes from the framer. The framer gives a frame number from 1 to 24 and a one-cycle strobe at each framing-bit position. The strobe of frame 24 marks the multiframe end. A single mode input selects the buffer depth for both directions. With the mode at 0, 12 bits are serviced every multiframe. With the mode at 1, 24 bits are serviced every second multiframe, so a repeating message can be sent without a processor write in every multiframe. A separate enable gates transmit insertion.

Top module: `esf_dl_buffer`

## Requirements
- R1: A data-link bit is taken from `rx_bit` only on an `f_strobe` cycle whose `frame_num` is odd (1, 3, ..., 23). The value on even frames has no effect on `rx_regs`.
- R2: Bits are packed LSB-first. The k-th data-link bit of a set lands in bit k of `rx_regs`, and the k-th bit sent is bit k of the transmit shadow. In mode 1 the first multiframe fills bits 11:0 and the second fills bits 23:12.
- R3: In mode 0, `rx_regs` loads the completed 12-bit set on the `f_strobe` of frame 24, with bits 23:12 equal to zero, and `rx_irq` is set on the same edge.
- R4: In mode 1, `rx_regs` loads and `rx_irq` is set only on every second multiframe end, when 24 bits have been collected.
- R5: `rx_regs` changes only on a frame-24 strobe that completes a set. In the middle of a multiframe it holds its previous value.
- R6: On the frame-24 strobe that starts a new transmit set, the write registers are copied into the transmit shadow and `tx_irq` is set. In mode 0 only bits 11:0 are copied. In mode 1 this happens every second multiframe.
- R7: During an odd frame, `tx_bit` equals the shadow bit for that position. While `tx_en` is 0, `tx_bit` is 1.
- R8: `rx_irq` and `tx_irq` stay set until a one-cycle pulse on `rx_irq_clr` or `tx_irq_clr`, respectively, clears them.
- R9: A change of `dl_mode` takes effect at the next frame-24 strobe. That strobe restarts bit counting for both directions, and a partly filled mode-1 set is dropped without loading `rx_regs` or setting `rx_irq`.
- R10: After reset, `rx_regs` is 0, both interrupts are 0 and `tx_bit` is 1. The first frame-24 strobe only aligns the block: it does not load `rx_regs`, and `tx_bit` stays 1 in all frames before it.
- R11: The write port maps `wr_addr` 0, 1 and 2 to shadow-source bits 7:0, 15:8 and 23:16. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_num | input | 5 | Current frame number, 1 to 24 |
| f_strobe | input | 1 | One-cycle pulse at the framing-bit position |
| dl_mode | input | 1 | 0: 12-bit buffer, 1: 24-bit buffer |
| tx_en | input | 1 | Transmit insertion enable |
| rx_bit | input | 1 | Received framing-bit value |
| tx_bit | output | 1 | Data-link bit to insert |
| rx_regs | output | 24 | Read registers, three bytes |
| rx_irq | output | 1 | Receive set-ready flag |
| rx_irq_clr | input | 1 | Clears `rx_irq` |
| wr_en | input | 1 | Write strobe for the transmit registers |
| wr_addr | input | 2 | Byte select |
| wr_data | input | 8 | Write byte |
| tx_irq | output | 1 | Transmit data-request flag |
| tx_irq_clr | input | 1 | Clears `tx_irq` |

## Verification
The bench drives the complement of the wanted bit on every even frame. A design that sampled even frames would therefore shift wrong data into the read registers. The bench reads `rx_regs` halfway through each multiframe, to catch a design that updates the read registers bit by bit instead of as one set. It switches to mode 1 and checks that the halfway multiframe end raises neither interrupt. It then returns to mode 0 halfway through a mode-1 set: a design that kept its counter would merge stale bits or commit half a set. It also writes address 3 after loading the top byte, so a design that aliased that address onto byte 2 would send wrong high-half bits.

// File: rtl/esf_dl_pkg.sv
package esf_dl_pkg;
  typedef enum logic {
    DL_STD = 1'b0,
    DL_IMP = 1'b1
  } dl_mode_e;
endpackage

// File: rtl/esf_dl_timing.sv
module esf_dl_timing
  import esf_dl_pkg::*;
#(
  parameter int FRAMES  = 24,
  parameter int FRAME_W = 5,
  parameter int MF_BITS = 12,
  parameter int SET_MAX = 24,
  parameter int CNT_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FRAME_W-1:0] frame_num,
  input  logic               f_strobe,
  input  dl_mode_e           mode_in,
  output logic               dl_slot,
  output logic               mf_end,
  output logic [CNT_W-1:0]   bit_idx,
  output logic               set_full,
  output logic               set_restart,
  output dl_mode_e           mode_act,
  output logic               synced
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  dl_mode_e         mode_q, mode_n;
  logic             sync_q, sync_n;
  logic [CNT_W-1:0] set_bits;
  logic             keep_going;

  assign dl_slot  = f_strobe && frame_num[0] && (frame_num < FRAME_W'(FRAMES));
  assign mf_end   = f_strobe && (frame_num == FRAME_W'(FRAMES));
  assign set_bits = (mode_q == DL_IMP) ? CNT_W'(SET_MAX) : CNT_W'(MF_BITS);
  assign set_full = sync_q && (cnt_q == set_bits);
  assign keep_going = sync_q && (mode_in == mode_q) && (mode_q == DL_IMP)
                      && (cnt_q == CNT_W'(MF_BITS));
  assign set_restart = mf_end && !keep_going;

  always_comb begin
    cnt_n  = cnt_q;
    mode_n = mode_q;
    sync_n = sync_q;
    if (mf_end) begin
      sync_n = 1'b1;
      mode_n = mode_in;
      if (!keep_going) cnt_n = '0;
    end else if (dl_slot && sync_q && (cnt_q < CNT_W'(SET_MAX))) begin
      cnt_n = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      mode_q <= DL_STD;
      sync_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      mode_q <= mode_n;
      sync_q <= sync_n;
    end
  end

  assign bit_idx  = cnt_q;
  assign mode_act = mode_q;
  assign synced   = sync_q;

  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(SET_MAX));
  p_restart_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_restart |=> (cnt_q == '0));
  p_std_depth_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == DL_STD) |-> (cnt_q <= CNT_W'(MF_BITS)));
endmodule

// File: rtl/esf_dl_rx.sv
module esf_dl_rx
  import esf_dl_pkg::*;
#(
  parameter int MF_BITS = 12,
  parameter int SET_MAX = 24,
  parameter int CNT_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dl_slot,
  input  logic               synced,
  input  logic               mf_end,
  input  logic               set_full,
  input  dl_mode_e           mode_act,
  input  logic [CNT_W-1:0]   bit_idx,
  input  logic               rx_bit,
  input  logic               irq_clr,
  output logic [SET_MAX-1:0] rx_regs,
  output logic               rx_irq
);
  localparam logic [SET_MAX-1:0] STD_MASK =
    {{(SET_MAX-MF_BITS){1'b0}}, {MF_BITS{1'b1}}};

  logic [SET_MAX-1:0] shad_q, shad_n;
  logic [SET_MAX-1:0] regs_q, regs_n;
  logic               irq_q, irq_n;
  logic               commit;

  assign commit = mf_end && set_full;

  always_comb begin
    shad_n = shad_q;
    if (dl_slot && synced && (bit_idx < CNT_W'(SET_MAX))) shad_n[bit_idx] = rx_bit;
    regs_n = regs_q;
    if (commit) regs_n = (mode_act == DL_IMP) ? shad_q : (shad_q & STD_MASK);
    irq_n = commit || (irq_q && !irq_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shad_q <= '0;
      regs_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      shad_q <= shad_n;
      regs_q <= regs_n;
      irq_q  <= irq_n;
    end
  end

  assign rx_regs = regs_q;
  assign rx_irq  = irq_q;

  p_atomic_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(regs_q));
  p_commit_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> irq_q);
  p_std_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && mode_act == DL_STD) |=> (regs_q[SET_MAX-1:MF_BITS] == '0));
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_clr) |=> irq_q);
endmodule

// File: rtl/esf_dl_tx.sv
module esf_dl_tx
  import esf_dl_pkg::*;
#(
  parameter int MF_BITS = 12,
  parameter int SET_MAX = 24,
  parameter int CNT_W   = 5,
  parameter int REG_W   = 8,
  parameter int NREG    = 3,
  parameter int ADDR_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              mf_end,
  input  logic              set_restart,
  input  dl_mode_e          mode_next,
  input  logic              synced,
  input  logic [CNT_W-1:0]  bit_idx,
  input  logic              tx_en,
  input  logic              irq_clr,
  output logic              tx_bit,
  output logic              tx_irq
);
  localparam logic [SET_MAX-1:0] STD_MASK =
    {{(SET_MAX-MF_BITS){1'b0}}, {MF_BITS{1'b1}}};

  logic [SET_MAX-1:0] wregs_q;
  logic [SET_MAX-1:0] shad_q, shad_n;
  logic               irq_q, irq_n;
  logic               load;
  logic               tx_on;

  for (genvar g = 0; g < NREG; g++) begin : g_wreg
    logic             sel;
    logic [REG_W-1:0] byte_n;
    assign sel = wr_en && (wr_addr == ADDR_W'(g));
    always_comb byte_n = sel ? wr_data : wregs_q[g*REG_W +: REG_W];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wregs_q[g*REG_W +: REG_W] <= '0;
      else        wregs_q[g*REG_W +: REG_W] <= byte_n;
    end
  end

  assign load = mf_end && set_restart;

  always_comb begin
    shad_n = shad_q;
    if (load) shad_n = (mode_next == DL_IMP) ? wregs_q : (wregs_q & STD_MASK);
    irq_n = load || (irq_q && !irq_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shad_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      shad_q <= shad_n;
      irq_q  <= irq_n;
    end
  end

  assign tx_on  = tx_en && synced && (bit_idx < CNT_W'(SET_MAX));
  assign tx_bit = tx_on ? shad_q[bit_idx] : 1'b1;
  assign tx_irq = irq_q;

  p_idle_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> tx_bit);
  p_load_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> irq_q);
  p_shadow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(shad_q));
  p_tx_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_clr) |=> irq_q);
endmodule

// File: rtl/esf_dl_buffer.sv
module esf_dl_buffer
  import esf_dl_pkg::*;
#(
  parameter int FRAMES = 24,
  parameter int REG_W  = 8,
  localparam int MF_BITS = FRAMES / 2,
  localparam int SET_MAX = 2 * MF_BITS,
  localparam int NREG    = SET_MAX / REG_W,
  localparam int FRAME_W = $clog2(FRAMES + 1),
  localparam int CNT_W   = $clog2(SET_MAX + 1),
  localparam int ADDR_W  = $clog2(NREG + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FRAME_W-1:0] frame_num,
  input  logic               f_strobe,
  input  logic               dl_mode,
  input  logic               tx_en,
  input  logic               rx_bit,
  output logic               tx_bit,
  output logic [SET_MAX-1:0] rx_regs,
  output logic               rx_irq,
  input  logic               rx_irq_clr,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [REG_W-1:0]   wr_data,
  output logic               tx_irq,
  input  logic               tx_irq_clr
);
  logic             dl_slot, mf_end, set_full, set_restart, synced;
  logic [CNT_W-1:0] bit_idx;
  dl_mode_e         mode_act, mode_in;

  assign mode_in = dl_mode_e'(dl_mode);

  esf_dl_timing #(
    .FRAMES(FRAMES), .FRAME_W(FRAME_W), .MF_BITS(MF_BITS),
    .SET_MAX(SET_MAX), .CNT_W(CNT_W)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .frame_num(frame_num), .f_strobe(f_strobe),
    .mode_in(mode_in), .dl_slot(dl_slot), .mf_end(mf_end), .bit_idx(bit_idx),
    .set_full(set_full), .set_restart(set_restart), .mode_act(mode_act),
    .synced(synced)
  );

  esf_dl_rx #(
    .MF_BITS(MF_BITS), .SET_MAX(SET_MAX), .CNT_W(CNT_W)
  ) u_rx (
    .clk(clk), .rst_n(rst_n), .dl_slot(dl_slot), .synced(synced),
    .mf_end(mf_end), .set_full(set_full), .mode_act(mode_act),
    .bit_idx(bit_idx), .rx_bit(rx_bit), .irq_clr(rx_irq_clr),
    .rx_regs(rx_regs), .rx_irq(rx_irq)
  );

  esf_dl_tx #(
    .MF_BITS(MF_BITS), .SET_MAX(SET_MAX), .CNT_W(CNT_W),
    .REG_W(REG_W), .NREG(NREG), .ADDR_W(ADDR_W)
  ) u_tx (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mf_end(mf_end), .set_restart(set_restart),
    .mode_next(mode_in), .synced(synced), .bit_idx(bit_idx), .tx_en(tx_en),
    .irq_clr(tx_irq_clr), .tx_bit(tx_bit), .tx_irq(tx_irq)
  );
endmodule

// File: tb/esf_dl_buffer_bench.sv
`timescale 1ns/1ps
module esf_dl_buffer_bench;
  localparam real HALF = 2.5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  frame_num;
  logic        f_strobe, dl_mode, tx_en, rx_bit, tx_bit;
  logic [23:0] rx_regs;
  logic        rx_irq, rx_irq_clr, wr_en, tx_irq, tx_irq_clr;
  logic [1:0]  wr_addr;
  logic [7:0]  wr_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(HALF) clk = ~clk;

  esf_dl_buffer u_esf_dl_buffer (
    .clk(clk), .rst_n(rst_n), .frame_num(frame_num), .f_strobe(f_strobe),
    .dl_mode(dl_mode), .tx_en(tx_en), .rx_bit(rx_bit), .tx_bit(tx_bit),
    .rx_regs(rx_regs), .rx_irq(rx_irq), .rx_irq_clr(rx_irq_clr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .tx_irq(tx_irq),
    .tx_irq_clr(tx_irq_clr)
  );

  // each entry: {rx pattern[11:0], tx word[11:0]}
  localparam logic [23:0] VEC [6] = '{
    24'hA5C_3F1, 24'h000_FFF, 24'hFFF_000, 24'h123_ABC, 24'h801_7E0, 24'h5A5_C3C
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr_word(input logic [23:0] w);
    wr(2'd0, w[7:0]); wr(2'd1, w[15:8]); wr(2'd2, w[23:16]);
  endtask

  task automatic clr_both;
    @(negedge clk); rx_irq_clr = 1'b1; tx_irq_clr = 1'b1;
    @(negedge clk); rx_irq_clr = 1'b0; tx_irq_clr = 1'b0;
  endtask

  // one multiframe; even frames carry the complement of a pattern bit
  task automatic do_mf(input logic [11:0] rxp, output logic [11:0] seen,
                       output logic [23:0] mid);
    seen = '0; mid = '0;
    for (int f = 1; f <= 24; f++) begin
      @(negedge clk);
      frame_num = 5'(f);
      rx_bit = (f % 2 == 1) ? rxp[(f-1)/2] : ~rxp[(f/2) % 12];
      f_strobe = 1'b1;
      #1;
      if (f % 2 == 1) seen[(f-1)/2] = tx_bit;
      if (f == 12) mid = rx_regs;
      @(negedge clk); f_strobe = 1'b0;
    end
    @(negedge clk);
  endtask

  initial begin
    #(HALF * 2 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [11:0] seen;
    logic [23:0] mid, prev, wx, wy;
    logic [11:0] pa, pb, pc, pd, pe;
    rst_n = 1'b0; frame_num = 5'd24; f_strobe = 1'b0; dl_mode = 1'b0;
    tx_en = 1'b0; rx_bit = 1'b0; rx_irq_clr = 1'b0; tx_irq_clr = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset rx_regs", 32'(rx_regs), 32'h0);
    chk("R10 reset rx_irq", 32'(rx_irq), 32'h0);
    chk("R10 reset tx_irq", 32'(tx_irq), 32'h0);
    chk("R10 reset tx_bit", 32'(tx_bit), 32'h1);

    tx_en = 1'b1;
    wr_word({12'h0, VEC[0][11:0]});
    do_mf(12'h5A5, seen, mid);
    chk("R10 idle before align", 32'(seen), 32'hFFF);
    chk("R10 no rx load on align", 32'(rx_irq), 32'h0);
    chk("R6 tx load on align", 32'(tx_irq), 32'h1);
    clr_both;
    chk("R8 rx_irq cleared", 32'(rx_irq), 32'h0);
    chk("R8 tx_irq cleared", 32'(tx_irq), 32'h0);

    prev = '0;
    for (int i = 0; i < 6; i++) begin
      wr_word((i < 5) ? {12'h0, VEC[i+1][11:0]} : 24'h0);
      do_mf(VEC[i][23:12], seen, mid);
      chk("R7 R2 tx bits std", 32'(seen), 32'(VEC[i][11:0]));
      chk("R1 R3 rx_regs std", 32'(rx_regs), 32'({12'h0, VEC[i][23:12]}));
      chk("R5 rx_regs held mid-frame", 32'(mid), 32'(prev));
      chk("R3 rx_irq std", 32'(rx_irq), 32'h1);
      chk("R6 tx_irq std", 32'(tx_irq), 32'h1);
      if (i == 0) begin
        repeat (3) @(negedge clk);
        chk("R8 rx_irq sticky", 32'(rx_irq), 32'h1);
        chk("R8 tx_irq sticky", 32'(tx_irq), 32'h1);
      end
      prev = {12'h0, VEC[i][23:12]};
      clr_both;
    end

    // switch to mode 1; takes effect at the end of multiframe A
    pa = 12'h3C5; pb = 12'h9E1; pc = 12'h47B; pd = 12'hF0F; pe = 12'h6D2;
    wx = 24'hC3_96_E1; wy = 24'h5B_A7_2D;
    dl_mode = 1'b1;
    wr_word(wx);
    wr(2'd3, 8'h00);
    do_mf(pa, seen, mid);
    chk("R9 mode change waits for boundary, tx", 32'(seen), 32'h0);
    chk("R9 std commit before switch", 32'(rx_regs), 32'({12'h0, pa}));
    chk("R9 rx_irq before switch", 32'(rx_irq), 32'h1);
    chk("R6 tx_irq at improved load", 32'(tx_irq), 32'h1);
    clr_both;
    do_mf(pb, seen, mid);
    chk("R2 R6 improved low half sent", 32'(seen), 32'(wx[11:0]));
    chk("R4 no rx load halfway", 32'(rx_regs), 32'({12'h0, pa}));
    chk("R4 no rx_irq halfway", 32'(rx_irq), 32'h0);
    chk("R6 no tx_irq halfway", 32'(tx_irq), 32'h0);
    wr_word(wy);
    do_mf(pc, seen, mid);
    chk("R11 R2 improved high half sent", 32'(seen), 32'(wx[23:12]));
    chk("R5 rx_regs held in improved", 32'(mid), 32'({12'h0, pa}));
    chk("R2 R4 improved rx set", 32'(rx_regs), 32'({pc, pb}));
    chk("R4 rx_irq improved", 32'(rx_irq), 32'h1);
    chk("R6 tx_irq improved", 32'(tx_irq), 32'h1);
    clr_both;

    dl_mode = 1'b0;
    do_mf(pd, seen, mid);
    chk("R6 next improved load", 32'(seen), 32'(wy[11:0]));
    chk("R9 partial set dropped", 32'(rx_regs), 32'({pc, pb}));
    chk("R9 no rx_irq on partial", 32'(rx_irq), 32'h0);
    chk("R9 tx restart on mode change", 32'(tx_irq), 32'h1);
    clr_both;
    do_mf(pe, seen, mid);
    chk("R9 std after switch back, tx", 32'(seen), 32'(wy[11:0]));
    chk("R9 std after switch back, rx", 32'(rx_regs), 32'({12'h0, pe}));
    chk("R3 rx_irq after switch back", 32'(rx_irq), 32'h1);
    clr_both;

    tx_en = 1'b0;
    do_mf(12'h0, seen, mid);
    chk("R7 idle while disabled", 32'(seen), 32'hFFF);
    tx_en = 1'b1;
    do_mf(12'h0, seen, mid);
    chk("R7 insertion resumes", 32'(seen), 32'(wy[11:0]));

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule